// File: doc/BRIEF.md
# Burst Region and Alignment Monitor

This block is a passive observer for a pipelined bus address phase. On every cycle in which the bus is ready, it looks at the transfer type, address, transfer size and burst type. When a burst begins, it records which 1 KiB region holds the first address. Each later beat of that burst is compared against the recorded region. Separately, every active beat is checked for an address that is not a multiple of its transfer size.

A violation produces three results on the clock edge after the offending beat is sampled. A one-cycle pulse is raised. Two class bits say which rule broke. The address of the offending beat is captured. A sticky flag stays set until reset or an explicit clear, so that software-free test harnesses or a system error collector can poll it later. The block never drives the bus, never decodes slaves and never looks at data.

Top module: `burst_guard`

## Requirements
- R1: After reset, errPulse, errSticky, errClass and errAddr are all zero.
- R2: busTrans is encoded 2'b00 idle, 2'b01 busy, 2'b10 first beat, 2'b11 continuing beat. A beat is sampled only in a cycle with busReady high and busTrans[1] high. Idle beats, busy beats and cycles with busReady low never cause an error, whatever address or size they carry.
- R3: A sampled first beat records the region bits busAddr[31:10]. If busBurst is not 3'b000, the first beat opens the region. If busBurst is 3'b000 (single transfer), the first beat closes it. While the region is closed, continuing beats are not region-checked.
- R4: A sampled continuing beat in an open region whose busAddr[31:10] differs from the recorded region is a boundary error, reported as errClass bit 0. Continuing beats never update the recorded region.
- R5: busSize code n (0 byte, 1 halfword, 2 word, 3 doubleword, 4 quadword) requires busAddr[n-1:0] to be zero. A violation is reported as errClass bit 1. Byte beats are never flagged. Codes 5 to 7 are checked as code 4.
- R6: One beat that breaks both rules sets both errClass bits in the same report.
- R7: errPulse is high for exactly the one cycle after the clock edge that sampled the offending beat. errClass and errAddr load in that same cycle and hold their values until the next error.
- R8: errSticky is set together with errPulse and stays high until reset or until a cycle with clearErr high. If an error and clearErr arrive in the same cycle, the error wins and errSticky stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clearErr | input | 1 | Clears the sticky flag |
| busTrans | input | 2 | Transfer type of the observed beat |
| busAddr | input | 32 | Address of the observed beat |
| busSize | input | 3 | Transfer size code, log2 of the byte count |
| busBurst | input | 3 | Burst type; 3'b000 is a single transfer |
| busReady | input | 1 | High when the bus completes the phase this cycle |
| errPulse | output | 1 | One-cycle error report |
| errSticky | output | 1 | Sticky error flag |
| errClass | output | 2 | Bit 0 is a boundary error, bit 1 is a misalignment |
| errAddr | output | 32 | Address of the last offending beat |

## Verification
If the recorded region is wrong or stays open when it should not, the error shows up at the ports on the cycle after the next continuing beat. That beat either raises a false boundary report or fails to raise a due one. A wrong size mask shows up on the cycle after the first misaligned or aligned beat of the affected size. Every cycle, the bench compares the pulse, class, address and sticky flag against a model kept in the bench. A stale region, a lost sticky bit or a report that lasts too long therefore fails on the very cycle it appears.

// File: rtl/burst_guard_pkg.sv
package burst_guard_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  localparam int SIZE_W  = 3;
  localparam int BURST_W = 3;
  localparam logic [BURST_W-1:0] BURST_ONE = 3'b000;

  typedef struct packed {
    logic capture;   // first beat: load region register
    logic compare;   // continuing beat in an open region
    logic alignChk;  // any sampled active beat
  } strobe_t;

endpackage

// File: rtl/burst_guard_ctrl.sv
module burst_guard_ctrl
  import burst_guard_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         busTrans,
  input  logic [BURST_W-1:0] busBurst,
  input  logic               busReady,
  output strobe_t            st
);

  logic regionOpen;
  logic isFirst;
  logic isCont;

  always_comb begin
    isFirst     = busReady && (busTrans == TR_NONSEQ);
    isCont      = busReady && (busTrans == TR_SEQ);
    st.capture  = isFirst;
    st.compare  = isCont && regionOpen;
    st.alignChk = busReady && busTrans[1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        regionOpen <= 1'b0;
    else if (isFirst) regionOpen <= (busBurst != BURST_ONE);
  end

  // R3: a multi-beat first beat opens the region
  assert_region_opens_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busReady && busTrans == TR_NONSEQ && busBurst != BURST_ONE) |=> regionOpen);

  // R3: a single transfer closes the region
  assert_single_closes_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busReady && busTrans == TR_NONSEQ && busBurst == BURST_ONE) |=> !regionOpen);

  // R2: nothing is strobed without a ready cycle
  assert_no_strobe_unready_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busReady |-> (st == '0));

endmodule

// File: rtl/burst_guard_dp.sv
module burst_guard_dp
  import burst_guard_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int REGION_LSB = 10,
  parameter int MAX_SIZE   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clearErr,
  input  strobe_t           st,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [SIZE_W-1:0] busSize,
  output logic              errPulse,
  output logic              errSticky,
  output logic [1:0]        errClass,
  output logic [ADDR_W-1:0] errAddr
);

  localparam int REGION_W = ADDR_W - REGION_LSB;
  localparam logic [SIZE_W-1:0] MAX_CODE = SIZE_W'(MAX_SIZE);

  logic [REGION_W-1:0] regionReg;
  logic [SIZE_W-1:0]   effSize;
  logic [MAX_SIZE-1:0] alignMask;
  logic                crossHit;
  logic                alignHit;
  logic                anyHit;

  assign effSize = (busSize > MAX_CODE) ? MAX_CODE : busSize;

  for (genvar i = 0; i < MAX_SIZE; i++) begin : g_mask
    assign alignMask[i] = (effSize > SIZE_W'(i));
  end

  always_comb begin
    crossHit = st.compare && (busAddr[ADDR_W-1:REGION_LSB] != regionReg);
    alignHit = st.alignChk && (|(busAddr[MAX_SIZE-1:0] & alignMask));
    anyHit   = crossHit || alignHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           regionReg <= '0;
    else if (st.capture) regionReg <= busAddr[ADDR_W-1:REGION_LSB];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errPulse  <= 1'b0;
      errSticky <= 1'b0;
      errClass  <= 2'b00;
      errAddr   <= '0;
    end else begin
      errPulse <= anyHit;
      if (anyHit) begin
        errSticky <= 1'b1;
        errClass  <= {alignHit, crossHit};
        errAddr   <= busAddr;
      end else if (clearErr) begin
        errSticky <= 1'b0;
      end
    end
  end

  // R8: a report always leaves the sticky flag set
  assert_pulse_sets_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> errSticky);

  // R8: sticky holds without a clear
  assert_sticky_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (errSticky && !clearErr) |=> errSticky);

  // R7: a report always names at least one class
  assert_class_named_R7: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> (errClass != 2'b00));

  // R2: an unready cycle produces no report
  assert_unready_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !st.alignChk |=> !errPulse || $past(st.compare));

  // R5: byte beats never raise a misalignment report
  assert_byte_aligned_R5: assert property (@(posedge clk) disable iff (!rstN)
    (st.alignChk && busSize == '0) |=> !(errPulse && errClass[1]));

endmodule

// File: rtl/burst_guard.sv
module burst_guard
  import burst_guard_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int REGION_LSB = 10,
  parameter int MAX_SIZE   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clearErr,
  input  logic [1:0]        busTrans,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [2:0]        busSize,
  input  logic [2:0]        busBurst,
  input  logic              busReady,
  output logic              errPulse,
  output logic              errSticky,
  output logic [1:0]        errClass,
  output logic [ADDR_W-1:0] errAddr
);

  strobe_t st;

  burst_guard_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busTrans (busTrans),
    .busBurst (busBurst),
    .busReady (busReady),
    .st       (st)
  );

  burst_guard_dp #(
    .ADDR_W     (ADDR_W),
    .REGION_LSB (REGION_LSB),
    .MAX_SIZE   (MAX_SIZE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .clearErr  (clearErr),
    .st        (st),
    .busAddr   (busAddr),
    .busSize   (busSize),
    .errPulse  (errPulse),
    .errSticky (errSticky),
    .errClass  (errClass),
    .errAddr   (errAddr)
  );

endmodule

// File: tb/burst_guard_tb.sv
module burst_guard_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clearErr = 1'b0;
  logic [1:0]  busTrans = 2'b00;
  logic [31:0] busAddr = '0;
  logic [2:0]  busSize = '0;
  logic [2:0]  busBurst = '0;
  logic        busReady = 1'b0;
  logic        errPulse, errSticky;
  logic [1:0]  errClass;
  logic [31:0] errAddr;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  burst_guard u_dut (
    .clk(clk), .rstN(rstN), .clearErr(clearErr),
    .busTrans(busTrans), .busAddr(busAddr), .busSize(busSize),
    .busBurst(busBurst), .busReady(busReady),
    .errPulse(errPulse), .errSticky(errSticky),
    .errClass(errClass), .errAddr(errAddr)
  );

  typedef struct {
    logic        pulse;
    logic        sticky;
    logic [1:0]  cls;
    logic [31:0] addr;
    string       tag;
  } exp_t;

  exp_t expQ[$];

  // bench-side model state
  logic        mOpen = 1'b0;
  logic [21:0] mRegion = '0;
  logic        mSticky = 1'b0;
  logic [1:0]  mClass = 2'b00;
  logic [31:0] mAddr = '0;

  task automatic beat(input logic [1:0] tr, input logic [31:0] a,
                      input logic [2:0] sz, input logic [2:0] bu,
                      input logic rdy, input logic clr, input string tag);
    logic vb, va, p;
    logic [3:0] mask;
    int s;
    exp_t e;
    @(negedge clk);
    busTrans = tr; busAddr = a; busSize = sz; busBurst = bu;
    busReady = rdy; clearErr = clr;
    s = (sz > 3'd4) ? 4 : int'(sz);
    mask = 4'((1 << s) - 1);
    vb = rdy && tr == 2'b11 && mOpen && (a[31:10] != mRegion);
    va = rdy && tr[1] && ((a[3:0] & mask) != 4'd0);
    if (rdy && tr == 2'b10) begin
      mOpen = (bu != 3'b000);
      mRegion = a[31:10];
    end
    p = va || vb;
    if (p) begin
      mClass = {va, vb};
      mAddr = a;
      mSticky = 1'b1;
    end else if (clr) begin
      mSticky = 1'b0;
    end
    e.pulse = p; e.sticky = mSticky; e.cls = mClass; e.addr = mAddr; e.tag = tag;
    expQ.push_back(e);
  endtask

  // monitor: compare after each active edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        nChecks++;
        if (errPulse !== e.pulse || errSticky !== e.sticky ||
            errClass !== e.cls || errAddr !== e.addr) begin
          nFails++;
          $display("FAIL %s: got pulse=%0b sticky=%0b class=%b addr=%h, expected pulse=%0b sticky=%0b class=%b addr=%h",
                   e.tag, errPulse, errSticky, errClass, errAddr,
                   e.pulse, e.sticky, e.cls, e.addr);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: got running, expected finished");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    nChecks++;
    if (errPulse !== 1'b0 || errSticky !== 1'b0 || errClass !== 2'b00 || errAddr !== '0) begin
      nFails++;
      $display("FAIL R1: got pulse=%0b sticky=%0b class=%b addr=%h, expected all zero",
               errPulse, errSticky, errClass, errAddr);
    end
    rstN = 1'b1;

    // R3: legal incrementing burst inside one region
    beat(2'b10, 32'h0000_0400, 3'd2, 3'b001, 1'b1, 1'b0, "R3 first");
    beat(2'b11, 32'h0000_0404, 3'd2, 3'b001, 1'b1, 1'b0, "R3 seq");
    beat(2'b11, 32'h0000_0408, 3'd2, 3'b001, 1'b1, 1'b0, "R3 seq");
    // R4: burst walks over a region edge
    beat(2'b10, 32'h0000_07F8, 3'd2, 3'b001, 1'b1, 1'b0, "R4 first");
    beat(2'b11, 32'h0000_07FC, 3'd2, 3'b001, 1'b1, 1'b0, "R4 last in");
    beat(2'b11, 32'h0000_0800, 3'd2, 3'b001, 1'b1, 1'b0, "R4 cross");
    beat(2'b11, 32'h0000_0804, 3'd2, 3'b001, 1'b1, 1'b0, "R4 still out");
    // R7: class and address hold over quiet cycles
    beat(2'b00, 32'h0000_0000, 3'd0, 3'b000, 1'b1, 1'b0, "R7 hold");
    // R8: clear drops the sticky flag
    beat(2'b00, 32'h0000_0000, 3'd0, 3'b000, 1'b1, 1'b1, "R8 clear");
    beat(2'b00, 32'h0000_0000, 3'd0, 3'b000, 1'b1, 1'b0, "R8 stays clear");
    // R5: size alignment over all size codes
    beat(2'b10, 32'h0000_1001, 3'd1, 3'b000, 1'b1, 1'b0, "R5 half odd");
    beat(2'b10, 32'h0000_1003, 3'd0, 3'b000, 1'b1, 1'b0, "R5 byte");
    beat(2'b10, 32'h0000_1002, 3'd2, 3'b000, 1'b1, 1'b0, "R5 word");
    beat(2'b10, 32'h0000_1004, 3'd3, 3'b000, 1'b1, 1'b0, "R5 dword");
    beat(2'b10, 32'h0000_1008, 3'd4, 3'b000, 1'b1, 1'b0, "R5 quad bad");
    beat(2'b10, 32'h0000_1010, 3'd4, 3'b000, 1'b1, 1'b0, "R5 quad ok");
    beat(2'b10, 32'h0000_1008, 3'd7, 3'b000, 1'b1, 1'b0, "R5 clamp");
    beat(2'b10, 32'h0000_1018, 3'd3, 3'b000, 1'b1, 1'b1, "R5 dword ok");
    // R6: both rules broken on one beat
    beat(2'b10, 32'h0000_2000, 3'd2, 3'b011, 1'b1, 1'b0, "R6 first");
    beat(2'b11, 32'h0000_2401, 3'd1, 3'b011, 1'b1, 1'b0, "R6 both");
    // R2: wait states, busy and idle with bad addresses
    beat(2'b11, 32'h0000_2C03, 3'd2, 3'b011, 1'b0, 1'b1, "R2 unready");
    beat(2'b01, 32'h0000_2C03, 3'd2, 3'b011, 1'b1, 1'b0, "R2 busy");
    beat(2'b00, 32'h0000_3C01, 3'd4, 3'b011, 1'b1, 1'b0, "R2 idle");
    beat(2'b11, 32'h0000_2004, 3'd2, 3'b011, 1'b1, 1'b0, "R2 ready seq ok");
    // R3: single transfer closes the region
    beat(2'b10, 32'h0000_3000, 3'd2, 3'b000, 1'b1, 1'b0, "R3 single");
    beat(2'b11, 32'h0000_3400, 3'd2, 3'b000, 1'b1, 1'b0, "R3 closed");
    // R8: error beats a same-cycle clear
    beat(2'b10, 32'h0000_5000, 3'd2, 3'b001, 1'b1, 1'b0, "R8 first");
    beat(2'b11, 32'h0000_5402, 3'd2, 3'b001, 1'b1, 1'b1, "R8 error wins");
    beat(2'b00, 32'h0000_0000, 3'd0, 3'b000, 1'b1, 1'b0, "R7 pulse ends");
    beat(2'b00, 32'h0000_0000, 3'd0, 3'b000, 1'b1, 1'b0, "R7 idle");

    repeat (3) @(posedge clk);
    #3;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule